// File: doc/BRIEF.md
# External Bus Cycle Wait-State Sequencer

This block runs one external bus access at a time as a chain of clock phases. A plain access has four phases: T0, T1, T2 and T3. When the access has to be stretched, the sequencer repeats a pair of phases, a wait phase (Tw) and then T2 again, as many times as needed. Two sources set how long an access lasts. The first is a 4-bit wait count from a control register, captured when the access is accepted. The second is an active-low acknowledge input from the addressed device. The access takes whichever of the two asks for more waits. The acknowledge can keep the access waiting for as long as it stays high.

The core starts an access by raising `req` with the direction, address and write data, and it watches `phase`. A request is accepted while the sequencer is idle or in T3, so accesses can run back to back. The external strobe stays low for the whole active part of an access. In T3 the sequencer returns a one-phase `done` pulse, together with the read data taken from the bus at the end of the final T2.

Top module: `bus_wait_seq`

## Requirements
- R1: After reset, `phase` is 0 (idle), `strb_n` is 1, `done` is 0 and `bus_oe` is 0.
- R2: While idle with `req` low, `ack_n` has no effect: `phase` stays 0 and `strb_n` stays 1.
- R3: `phase` encodes idle=0, T0=1, T1=2, T2=3, Tw=4, T3=5. An access runs T0, T1, T2, then zero or more {Tw, T2} pairs, then T3. Every Tw is followed by T2. With `req` low in T3, the next phase is idle.
- R4: `ack_n` is looked at only during T2, by the clock edge that closes that T2. Once the register count has been met, low moves to T3 and high inserts a Tw.
- R5: At least N Tw phases are inserted, where N is `wait_cfg` captured on the edge that accepts the request. Any later change to `wait_cfg` has no effect on the running access.
- R6: The number of Tw phases is max(N, K), where K is the 0-based index of the first T2 during which `ack_n` is low. There is no upper bound on the waits while `ack_n` stays high.
- R7: If N is 0 and `ack_n` is low during T0, the access has no Tw phase, whatever `ack_n` is in T2.
- R8: `strb_n` is 0 in T0, T1, T2 and Tw, and 1 in T3 and idle. `bus_addr` and `bus_we` are held for the whole access. For a write, `bus_oe` is 1 and `bus_dout` equals the request's write data.
- R9: `done` is 1 for exactly the T3 phase. For a read, `rdata` in T3 equals `bus_din` as sampled at the edge that closes the final T2.
- R10: A request held high during T3 makes the very next phase T0, with no idle phase between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, one phase per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start request, accepted in idle or T3 |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| wait_cfg | input | WW | Register wait count |
| ack_n | input | 1 | Active-low transfer acknowledge |
| bus_din | input | DW | Read data from the bus |
| phase | output | 3 | Current phase code |
| bus_addr | output | AW | Address held for the access |
| bus_we | output | 1 | Direction held for the access |
| bus_dout | output | DW | Write data to the bus |
| bus_oe | output | 1 | Write data drive enable |
| strb_n | output | 1 | Active-low bus strobe |
| done | output | 1 | One-phase completion pulse in T3 |
| rdata | output | DW | Read data returned in T3 |

## Verification
Each output is registered, so a decision made from the inputs present during a phase appears in `phase` one clock later. The bench therefore drives `ack_n`, `bus_din` and `req` on the falling edge, after it has read `phase` for that phase. It then checks the result on the next falling edge. The Tw count, `done` and `rdata` are checked in the T3 that follows the final T2. The count is compared with max(N, K), or with zero for the fast case, computed arithmetically. A back-to-back start must show T0 exactly one phase after T3.

// File: rtl/bus_wait_seq.sv
module bus_wait_seq #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [WW-1:0] wait_cfg,
  input  logic          ack_n,
  input  logic [DW-1:0] bus_din,
  output logic [2:0]    phase,
  output logic [AW-1:0] bus_addr,
  output logic          bus_we,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  output logic          strb_n,
  output logic          done,
  output logic [DW-1:0] rdata
);

  typedef enum logic [2:0] {
    P_IDLE = 3'd0, P_T0 = 3'd1, P_T1 = 3'd2, P_T2 = 3'd3, P_TW = 3'd4, P_T3 = 3'd5
  } ph_e;

  ph_e           st, st_nx;
  logic [WW-1:0] wreg, wcnt;
  logic          t0_ack;

  wire start     = req && (st == P_IDLE || st == P_T3);
  wire quick     = (wreg == '0) && t0_ack;
  wire count_met = wcnt >= wreg;
  wire t2_exit   = count_met && (!ack_n || quick);
  wire active    = (st == P_T0) || (st == P_T1) || (st == P_T2) || (st == P_TW);

  assign phase  = st;
  assign strb_n = !active;
  assign bus_oe = active && bus_we;
  assign done   = (st == P_T3);

  always_comb begin
    st_nx = st;
    case (st)
      P_IDLE:  if (req) st_nx = P_T0;
      P_T0:    st_nx = P_T1;
      P_T1:    st_nx = P_T2;
      P_T2:    st_nx = t2_exit ? P_T3 : P_TW;
      P_TW:    st_nx = P_T2;
      P_T3:    st_nx = req ? P_T0 : P_IDLE;
      default: st_nx = P_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= P_IDLE;
      wreg     <= '0;
      wcnt     <= '0;
      t0_ack   <= 1'b0;
      bus_addr <= '0;
      bus_we   <= 1'b0;
      bus_dout <= '0;
      rdata    <= '0;
    end else begin
      st <= st_nx;
      if (start) begin
        wreg     <= wait_cfg;
        wcnt     <= '0;
        bus_addr <= req_addr;
        bus_we   <= req_we;
        bus_dout <= req_wdata;
      end
      if (st == P_T0) t0_ack <= !ack_n;
      if (st == P_TW && wcnt != '1) wcnt <= wcnt + 1'b1;
      if (st == P_T2 && t2_exit && !bus_we) rdata <= bus_din;
    end
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == P_IDLE && !req) |=> (st == P_IDLE)); // R2
  AST_WAIT_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == P_TW) |=> (st == P_T2)); // R3
  AST_ACK_HIGH_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == P_T2 && ack_n && !quick) |=> (st == P_TW)); // R4
  AST_MIN_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == P_T2 && wcnt < wreg) |=> (st == P_TW)); // R5
  AST_FAST_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == P_T2 && wreg == '0 && t0_ack) |=> (st == P_T3)); // R7
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == P_T1 || st == P_T2 || st == P_TW || st == P_T3) |-> $stable(bus_addr)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_CHAINED_START: assert property (@(posedge clk) disable iff (!rst_n)
    (st == P_T3 && req) |=> (st == P_T0)); // R10

endmodule

// File: tb/bus_wait_seq_tb.sv
`timescale 1ns/1ps
module bus_wait_seq_tb;
  localparam int AW = 16, DW = 16, WW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, req_we = 1'b0, ack_n = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, bus_din = '0;
  logic [WW-1:0] wait_cfg = '0;
  logic [2:0] phase;
  logic [AW-1:0] bus_addr;
  logic bus_we, bus_oe, strb_n, done;
  logic [DW-1:0] bus_dout, rdata;

  int checks = 0, failures = 0, cyc = 0;

  always #2.5 clk = ~clk;

  bus_wait_seq #(.AW(AW), .DW(DW), .WW(WW)) u_dut (
    .clk, .rst_n, .req, .req_we, .req_addr, .req_wdata, .wait_cfg, .ack_n, .bus_din,
    .phase, .bus_addr, .bus_we, .bus_dout, .bus_oe, .strb_n, .done, .rdata);

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic run_cycle(input int n, input int kk, input bit a0, input bit we,
                           input bit chained, input int seed);
    int t2idx = 0, tw = 0, expw;
    logic [DW-1:0] last_din = '0;
    logic [AW-1:0] a = AW'(seed * 37 + 5);
    logic [DW-1:0] w = DW'(seed * 91 + 3);
    expw = (n == 0 && a0 == 1'b0) ? 0 : ((n > kk) ? n : kk);
    req = 1'b1; req_we = we; req_addr = a; req_wdata = w; wait_cfg = WW'(n);
    @(negedge clk);
    if (chained) chk(phase == 3'd1, "R10 chained start", phase, 1);
    else         chk(phase == 3'd1, "R3 start phase", phase, 1);
    req = 1'b0; wait_cfg = WW'(n) ^ '1; ack_n = a0;
    req_addr = ~a;
    forever begin
      @(negedge clk);
      bus_din = DW'($urandom);
      case (phase)
        3'd2: begin
          ack_n = ~ack_n;
          chk(strb_n == 1'b0, "R8 strobe T1", strb_n, 0);
          chk(bus_addr == a && bus_we == we, "R8 addr held", bus_addr, a);
          if (we) chk(bus_oe && bus_dout == w, "R8 write drive", bus_dout, w);
          else    chk(!bus_oe, "R8 no drive on read", bus_oe, 0);
        end
        3'd3: begin
          ack_n = (t2idx >= kk) ? 1'b0 : 1'b1;
          last_din = bus_din;
          t2idx++;
          chk(strb_n == 1'b0 && !done, "R8 strobe T2", strb_n, 0);
        end
        3'd4: begin
          tw++;
          ack_n = ~ack_n;
          chk(strb_n == 1'b0 && !done, "R3 wait phase", strb_n, 0);
        end
        3'd5: break;
        default: begin
          chk(1'b0, "R3 illegal phase", phase, 3);
          break;
        end
      endcase
      if (tw > 40) begin
        chk(1'b0, "R6 runaway wait", tw, expw);
        break;
      end
    end
    chk(phase == 3'd5, "R3 ends in T3", phase, 5);
    chk(tw == expw, (n == 0 && !a0) ? "R7 fast cycle waits" : "R6 wait count", tw, expw);
    chk(tw >= n || (n == 0), "R5 register minimum", tw, n);
    chk(done && strb_n, "R9 done in T3", done, 1);
    if (!we) chk(rdata == last_din, "R9 read data", rdata, last_din);
    if (!chained) begin
      @(negedge clk);
      chk(phase == 3'd0 && !done, "R3 return idle", phase, 0);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    int seed = 0;
    repeat (3) @(negedge clk);
    chk(phase == 3'd0 && strb_n && !done && !bus_oe, "R1 reset state", phase, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      ack_n = i[0];
      @(negedge clk);
      chk(phase == 3'd0 && strb_n, "R2 idle ignores ack", phase, 0);
    end
    for (int n = 0; n < 16; n++)
      for (int kk = 0; kk < 18; kk++)
        for (int a0 = 0; a0 < 2; a0++) begin
          seed++;
          run_cycle(n, kk, a0[0], seed[0], (seed % 3) == 0, seed);
          if ((seed % 3) == 0) run_cycle(kk % 3, 0, 1'b0, 1'b0, 1'b1, seed + 7);
          if ((seed % 3) == 0) begin
            req = 1'b0;
            @(negedge clk);
            chk(phase == 3'd0, "R3 idle after chain", phase, 0);
          end
        end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule